// File: doc/BRIEF.md
# Packed SIMD Integer Arithmetic Unit

This unit is a 64-bit packed integer datapath. Each cycle it can accept one command made of a 3-bit operation code and two 64-bit operands, `a` and `b`. It returns one 64-bit result that replaces `a` in the caller's register. The result arrives with a fixed latency of two clock edges.

Byte commands split each operand into eight unsigned 8-bit lanes. Word commands split each operand into four 16-bit lanes. Whether the lanes are signed or unsigned depends on the operation code. The unit supports:
- rounded-up averaging;
- lane-wise maximum and minimum;
- the upper half of an unsigned product;
- a sum of absolute byte differences, reduced across all lanes into one 16-bit field.

The first pipeline stage runs the lane arithmetic. The second stage performs the cross-lane reduction and selects the result. `res_o` keeps its last value while no result is being delivered.

Top module: `simd_alu`

## Requirements
- R1: Operation code 0 (byte average) returns, for each of the eight unsigned byte lanes, (a + b + 1) >> 1, computed without losing the carry.
- R2: Operation code 1 (word average) returns, for each of the four unsigned 16-bit lanes, (a + b + 1) >> 1, computed without losing the carry.
- R3: Operation codes 2 (word maximum) and 3 (word minimum) compare each 16-bit lane as a signed two's-complement value. For example, 0x8000 is treated as smaller than 0x7FFF.
- R4: Operation codes 4 (byte maximum) and 5 (byte minimum) compare each 8-bit lane as an unsigned value. For example, 0x80 is treated as larger than 0x7F.
- R5: Operation code 6 multiplies each pair of unsigned 16-bit lanes and returns bits 31:16 of each 32-bit product in that lane.
- R6: Operation code 7 places the sum of the eight unsigned absolute byte differences |a - b| in result bits 15:0. The sum never exceeds 2040 and is never saturated.
- R7: For operation code 7, result bits 63:16 are zero.
- R8: `vld_o` is high exactly two rising clock edges after the edge that sampled `vld_i` high, and is low otherwise.
- R9: A synchronous reset (`rst` high) clears `vld_o` and `res_o` to zero and discards any commands in flight.
- R10: While `vld_o` is low, `res_o` keeps the value of the last delivered result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Command valid |
| op_i | input | 3 | Operation code |
| a_i | input | 64 | First operand, replaced by the result |
| b_i | input | 64 | Second operand |
| vld_o | output | 1 | Result valid |
| res_o | output | 64 | Result |

## Verification
Every result is due two rising edges after the edge that samples its command, so it can be seen at the second falling edge after the command is driven. The bench drives its inputs on falling edges and keeps a two-entry history of its own issue flags. At each falling edge it shifts this history and checks `vld_o` against the oldest entry. When a result is due, the bench takes it from a queue of results computed by its behavioural model. When no result is due, it checks that `res_o` still holds the last delivered value. Commands mix edge-value lanes (0x00, 0x7F, 0x80, 0xFF) with random operands and random bubbles. A reset is also applied while commands are in flight.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [2:0] {
        OP_AVG8    = 3'd0,
        OP_AVG16   = 3'd1,
        OP_SMAX16  = 3'd2,
        OP_SMIN16  = 3'd3,
        OP_UMAX8   = 3'd4,
        OP_UMIN8   = 3'd5,
        OP_MULHI16 = 3'd6,
        OP_SAD8    = 3'd7
    } simd_op_e;

endpackage

// File: rtl/simd_lane8.sv
module simd_lane8 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg,
    output logic [W-1:0] umax,
    output logic [W-1:0] umin,
    output logic [W-1:0] adiff
);
    logic [W:0] sum_w;
    logic       a_ge;

    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
        avg   = sum_w[W:1];
        a_ge  = (a >= b);
        umax  = a_ge ? a : b;
        umin  = a_ge ? b : a;
        adiff = a_ge ? (a - b) : (b - a);
    end
endmodule

// File: rtl/simd_lane16.sv
module simd_lane16 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg,
    output logic [W-1:0] smax,
    output logic [W-1:0] smin,
    output logic [W-1:0] mulhi
);
    logic [W:0]     sum_w;
    logic [2*W-1:0] prod;
    logic           a_gt;

    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
        avg   = sum_w[W:1];
        a_gt  = ($signed(a) > $signed(b));
        smax  = a_gt ? a : b;
        smin  = a_gt ? b : a;
        prod  = a * b;
        mulhi = prod[2*W-1:W];
    end
endmodule

// File: rtl/simd_sad_sum.sv
module simd_sad_sum #(
    parameter int N     = 8,
    parameter int W     = 8,
    parameter int OUT_W = 16
) (
    input  logic [N*W-1:0] ad,
    output logic [OUT_W-1:0] sum
);
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + OUT_W'(ad[i*W +: W]);
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] res_o
);
    localparam int B_W   = 8;
    localparam int H_W   = 16;
    localparam int N8    = DATA_W / B_W;
    localparam int N16   = DATA_W / H_W;
    localparam int SAD_W = 16;

    typedef struct packed {
        logic              vld;
        simd_op_e          op;
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] ad;
    } stage1_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic [DATA_W-1:0] avg8_w, umax8_w, umin8_w, ad8_w;
    logic [DATA_W-1:0] avg16_w, smax16_w, smin16_w, mulhi16_w;
    logic [SAD_W-1:0]  sad_w;

    for (genvar g = 0; g < N8; g++) begin : g_lane8
        simd_lane8 #(.W(B_W)) i_lane8 (
            .a     (a_i[g*B_W +: B_W]),
            .b     (b_i[g*B_W +: B_W]),
            .avg   (avg8_w[g*B_W +: B_W]),
            .umax  (umax8_w[g*B_W +: B_W]),
            .umin  (umin8_w[g*B_W +: B_W]),
            .adiff (ad8_w[g*B_W +: B_W])
        );
    end

    for (genvar g = 0; g < N16; g++) begin : g_lane16
        simd_lane16 #(.W(H_W)) i_lane16 (
            .a     (a_i[g*H_W +: H_W]),
            .b     (b_i[g*H_W +: H_W]),
            .avg   (avg16_w[g*H_W +: H_W]),
            .smax  (smax16_w[g*H_W +: H_W]),
            .smin  (smin16_w[g*H_W +: H_W]),
            .mulhi (mulhi16_w[g*H_W +: H_W])
        );
    end

    simd_sad_sum #(.N(N8), .W(B_W), .OUT_W(SAD_W)) i_sad (
        .ad  (s1_q.ad),
        .sum (sad_w)
    );

    always_comb begin
        s1_d     = s1_q;
        s1_d.vld = vld_i;
        s1_d.op  = simd_op_e'(op_i);
        s1_d.ad  = ad8_w;
        unique case (simd_op_e'(op_i))
            OP_AVG8:    s1_d.res = avg8_w;
            OP_AVG16:   s1_d.res = avg16_w;
            OP_SMAX16:  s1_d.res = smax16_w;
            OP_SMIN16:  s1_d.res = smin16_w;
            OP_UMAX8:   s1_d.res = umax8_w;
            OP_UMIN8:   s1_d.res = umin8_w;
            OP_MULHI16: s1_d.res = mulhi16_w;
            default:    s1_d.res = '0;
        endcase

        s2_d     = s2_q;
        s2_d.vld = s1_q.vld;
        if (s1_q.vld) begin
            if (s1_q.op == OP_SAD8) begin
                s2_d.res = {{(DATA_W-SAD_W){1'b0}}, sad_w};
            end else begin
                s2_d.res = s1_q.res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign vld_o = s2_q.vld;
    assign res_o = s2_q.res;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              vld_i,
    input logic [2:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              vld_o,
    input logic [DATA_W-1:0] res_o
);
    localparam int N8  = DATA_W / 8;
    localparam int N16 = DATA_W / 16;

    logic              v1_q, v2_q;
    logic [2:0]        op1_q, op2_q;
    logic [DATA_W-1:0] a1_q, a2_q, b1_q, b2_q;
    logic              umax_ok, smin_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= vld_i;
            v2_q <= v1_q;
        end
        op1_q <= op_i;
        op2_q <= op1_q;
        a1_q  <= a_i;
        a2_q  <= a1_q;
        b1_q  <= b_i;
        b2_q  <= b1_q;
    end

    always_comb begin
        umax_ok = 1'b1;
        for (int i = 0; i < N8; i++) begin
            if (res_o[i*8 +: 8] < a2_q[i*8 +: 8] || res_o[i*8 +: 8] < b2_q[i*8 +: 8]) begin
                umax_ok = 1'b0;
            end
        end
        smin_ok = 1'b1;
        for (int i = 0; i < N16; i++) begin
            if ($signed(res_o[i*16 +: 16]) > $signed(a2_q[i*16 +: 16]) ||
                $signed(res_o[i*16 +: 16]) > $signed(b2_q[i*16 +: 16])) begin
                smin_ok = 1'b0;
            end
        end
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst) vld_o == v2_q);

    // R7
    sad_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && op2_q == 3'd7) |-> (res_o[DATA_W-1:16] == '0));

    // R6
    sad_range_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && op2_q == 3'd7) |-> (res_o[15:0] <= 16'(N8 * 255)));

    // R4
    umax_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && op2_q == 3'd4) |-> umax_ok);

    // R3
    smin_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_o && op2_q == 3'd3) |-> smin_ok);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> $stable(res_o));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!vld_o && res_o == '0));
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) i_simd_alu_chk (.*);

// File: tb/test_simd_alu.sv
module test_simd_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        vld_o;
    logic [63:0] res_o;

    int checks = 0;
    int fails  = 0;

    logic [63:0] exp_q[$];
    logic [2:0]  op_q[$];
    logic        h1 = 1'b0, h2 = 1'b0;
    logic [63:0] last_res = '0;

    always #5 clk = ~clk;

    simd_alu i_simd_alu (
        .clk(clk), .rst(rst), .vld_i(vld_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .vld_o(vld_o), .res_o(res_o)
    );

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4, 3'd5: return "R4";
            3'd6: return "R5";
            default: return "R6/R7";
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        int          s = 0;
        for (int i = 0; i < 8; i++) begin
            int x = int'(a[i*8 +: 8]);
            int y = int'(b[i*8 +: 8]);
            case (op)
                3'd0: r[i*8 +: 8] = 8'((x + y + 1) / 2);
                3'd4: r[i*8 +: 8] = 8'((x > y) ? x : y);
                3'd5: r[i*8 +: 8] = 8'((x < y) ? x : y);
                3'd7: s += (x > y) ? (x - y) : (y - x);
                default: ;
            endcase
        end
        for (int i = 0; i < 4; i++) begin
            int x  = int'(a[i*16 +: 16]);
            int y  = int'(b[i*16 +: 16]);
            int sx = (x >= 32768) ? x - 65536 : x;
            int sy = (y >= 32768) ? y - 65536 : y;
            longint p = longint'(x) * longint'(y);
            case (op)
                3'd1: r[i*16 +: 16] = 16'((x + y + 1) / 2);
                3'd2: r[i*16 +: 16] = 16'((sx > sy) ? sx : sy);
                3'd3: r[i*16 +: 16] = 16'((sx < sy) ? sx : sy);
                3'd6: r[i*16 +: 16] = 16'(p / 65536);
                default: ;
            endcase
        end
        if (op == 3'd7) r = 64'(s);
        return r;
    endfunction

    task automatic check_now();
        checks++;
        if (vld_o !== h2) begin
            fails++;
            $display("FAIL R8 vld_o actual %0b expected %0b", vld_o, h2);
        end
        if (h2) begin
            logic [63:0] e  = exp_q.pop_front();
            logic [2:0]  op = op_q.pop_front();
            checks++;
            if (res_o !== e) begin
                fails++;
                $display("FAIL %s op %0d res actual %h expected %h", req_of(op), op, res_o, e);
            end
            last_res = e;
        end else begin
            checks++;
            if (res_o !== last_res) begin
                fails++;
                $display("FAIL R10 held res actual %h expected %h", res_o, last_res);
            end
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        check_now();
        h2 = h1;
        h1 = v;
        vld_i = v;
        op_i  = op;
        a_i   = a;
        b_i   = b;
        if (v) begin
            exp_q.push_back(model(op, a, b));
            op_q.push_back(op);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        vld_i = 1'b0;
        repeat (2) @(negedge clk);
        // R9: outputs cleared while reset is held
        checks++;
        if (vld_o !== 1'b0 || res_o !== '0) begin
            fails++;
            $display("FAIL R9 reset vld %0b res %h expected 0 0", vld_o, res_o);
        end
        exp_q.delete();
        op_q.delete();
        h1 = 1'b0;
        h2 = 1'b0;
        last_res = '0;
        rst = 1'b0;
    endtask

    function automatic logic [63:0] edge_word(input int sel);
        logic [7:0] ev[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        logic [63:0] w;
        for (int l = 0; l < 8; l++) w[l*8 +: 8] = ev[(sel + l * (sel / 4 + 1)) % 4];
        return w;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: state after power-up reset
        checks++;
        if (vld_o !== 1'b0 || res_o !== '0) begin
            fails++;
            $display("FAIL R9 power-up vld %0b res %h expected 0 0", vld_o, res_o);
        end
        rst = 1'b0;

        // edge lanes, every op, back to back
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 16; i++) begin
                step(1'b1, 3'(op), edge_word(i), edge_word(15 - i));
            end
        end
        // R3 and R4 sign boundary directed
        step(1'b1, 3'd2, 64'h7FFF_7FFF_8000_0000, 64'h8000_FFFF_7FFF_0001);
        step(1'b1, 3'd4, 64'h7F80_7F80_0000_00FF, 64'h807F_807F_FF00_0000);
        // R6 maximum sum, R7 upper bits
        step(1'b1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        // R5 largest product
        step(1'b1, 3'd6, 64'hFFFF_FFFF_0001_8000, 64'hFFFF_0001_FFFF_8000);

        // random with bubbles (R10)
        for (int i = 0; i < 3000; i++) begin
            logic v = ($urandom_range(0, 3) != 0);
            step(v, 3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom});
        end
        step(1'b0, 3'd0, '0, '0);
        step(1'b0, 3'd0, '0, '0);

        // R9: reset while commands are in flight
        step(1'b1, 3'd0, {$urandom, $urandom}, {$urandom, $urandom});
        step(1'b1, 3'd7, {$urandom, $urandom}, {$urandom, $urandom});
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b0, 3'd0, '0, '0);
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 3'($urandom_range(0, 7)), {$urandom, $urandom}, {$urandom, $urandom});
        end
        for (int i = 0; i < 3; i++) step(1'b0, 3'd0, '0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule